// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

This block is a watchdog peripheral on a plain 16-bit register bus. The bus has a byte offset, a write strobe, write data, a read strobe and read data. A 15-bit down-counter is clocked by a tick-enable input that pulses once every 10 ms, so the longest timeout is a little over 327 s. Software controls the block only by writing fixed 16-bit key values: one key reloads the counter, one key re-enables the watchdog, and two keys written back to back switch it off.

While the watchdog is counting, the tick before expiry sets an early-warning event. That event can be masked or forced, and software clears it by writing a one. At expiry the block pulses a reset request for one clock and latches a timed-out status that only a key can clear. The counter then reloads and counting goes on. A debug-mode input suspends counting unless an override bit has been set.

Reads are combinational. `rd_data` shows the addressed register while `rd_en` is high and reads 0 when `rd_en` is low. Writes take effect on the clock edge at which `wr_en` is high.

Top module: `kwdog_top`

## Requirements
- R1: Out of reset the watchdog is off. Offset 0x0C reads 0xDABE, offset 0x04 reads 6000, offset 0x14 reads 6000, offset 0x10 reads 0x0000, and both `irq` and `rst_req` are low.
- R2: Offset 0x04 stores the low 15 bits of the written value as the timeout and reads them back with bit 15 at 0. Unmapped offsets and the write-only offsets 0x00, 0x08 and 0x1C read 0.
- R3: Writing 0xACED to offset 0x1C while the watchdog is off turns it on, and offset 0x0C then reads 0x0000. The count does not move until 0xFEED is written to offset 0x00. That write reloads the count from the timeout and starts counting. Any other value written to offset 0x00 has no effect, and 0xFEED has no effect while the watchdog is off.
- R4: Each tick that arrives while the watchdog is counting lowers the count by one. The count holds when there is no tick and no bus write.
- R5: A counting tick that finds the count at 1 or 0 raises `rst_req` for exactly one clock after that edge. The same tick reloads the count from the timeout, and counting continues. From then on offset 0x10 reads 0xCFE8.
- R6: Writing 0xE8B4 to offset 0x10 clears the timed-out status back to 0x0000. Any other value written there leaves the status unchanged.
- R7: The watchdog turns off only when 0x2BAD is written to offset 0x08 and the very next bus write puts 0xCAFE at offset 0x0C. Any other write in between cancels the sequence. Once off, offset 0x0C reads 0xDABE and ticks no longer change the count.
- R8: A counting tick that finds the count at 2 sets the event in bit 0 of offset 0x20. Writing 1 to that bit clears the event. `irq` equals the event ANDed with mask bit 0 of offset 0x24.
- R9: Bit 0 of offset 0x28 reads back as written. While it is 1, the event stays set and an acknowledge cannot clear it.
- R10: Offset 0x18 reads the `dbg_mode` input in bit 1 and a read/write override in bit 0. While `dbg_mode` is high and the override is 0, ticks do not change the count.
- R11: Offset 0x14 returns the count in bits 14:0. Bit 15 reads 1 for the one clock that follows an edge at which the count changed value, and reads 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Count enable, one clock wide every 10 ms |
| dbg_mode | input | 1 | High while a debugger is attached |
| addr | input | 6 | Byte offset of the register accessed |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Read data, valid while rd_en is high |
| irq | output | 1 | Early-warning interrupt |
| rst_req | output | 1 | One-clock reset request at expiry |

## Verification
The bench targets the off-by-one edges of the counter. A design that fires the warning on the expiry tick, or that expires one tick late, fails the directed countdown from five and the random runs with timeouts of 0 and 1. It also interleaves other writes inside the two-key shutdown sequence: a design that remembers the first key past the next write shuts down when it should not. A design whose acknowledge beats the force bit, or whose status clears on any write, is caught by directed writes followed by reads. Reading the count in the clock right after a tick checks that the settling flag lasts exactly one clock.

// File: rtl/kwdog_pkg.sv
package kwdog_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned DATA_W = 16;

  localparam logic [ADDR_W-1:0] A_FEED   = 6'h00;
  localparam logic [ADDR_W-1:0] A_TMO    = 6'h04;
  localparam logic [ADDR_W-1:0] A_KILL1  = 6'h08;
  localparam logic [ADDR_W-1:0] A_KILL2  = 6'h0C;
  localparam logic [ADDR_W-1:0] A_STAT   = 6'h10;
  localparam logic [ADDR_W-1:0] A_CNT    = 6'h14;
  localparam logic [ADDR_W-1:0] A_JTAG   = 6'h18;
  localparam logic [ADDR_W-1:0] A_RESUME = 6'h1C;
  localparam logic [ADDR_W-1:0] A_EVT    = 6'h20;
  localparam logic [ADDR_W-1:0] A_MASK   = 6'h24;
  localparam logic [ADDR_W-1:0] A_FRC    = 6'h28;

  localparam logic [DATA_W-1:0] K_FEED   = 16'hFEED;
  localparam logic [DATA_W-1:0] K_KILL1  = 16'h2BAD;
  localparam logic [DATA_W-1:0] K_KILL2  = 16'hCAFE;
  localparam logic [DATA_W-1:0] K_RESUME = 16'hACED;
  localparam logic [DATA_W-1:0] K_STCLR  = 16'hE8B4;
  localparam logic [DATA_W-1:0] V_OFF    = 16'hDABE;
  localparam logic [DATA_W-1:0] V_TOUT   = 16'hCFE8;

  typedef struct packed {
    logic feed;
    logic resume;
    logic kill;
    logic tmo_we;
    logic stat_clr;
    logic ack;
    logic frc_we;
    logic mask_we;
    logic jtag_we;
  } ctl_t;
endpackage

// File: rtl/kwdog_keys.sv
module kwdog_keys
  import kwdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output ctl_t              ctl
);
  logic armed_q;

  always_comb begin
    ctl = '0;
    if (wr_en) begin
      case (addr)
        A_FEED:   ctl.feed     = (wr_data == K_FEED);
        A_TMO:    ctl.tmo_we   = 1'b1;
        A_KILL2:  ctl.kill     = armed_q && (wr_data == K_KILL2);
        A_STAT:   ctl.stat_clr = (wr_data == K_STCLR);
        A_RESUME: ctl.resume   = (wr_data == K_RESUME);
        A_EVT:    ctl.ack      = wr_data[0];
        A_FRC:    ctl.frc_we   = 1'b1;
        A_MASK:   ctl.mask_we  = 1'b1;
        A_JTAG:   ctl.jtag_we  = 1'b1;
        default:  ctl = '0;
      endcase
    end
  end

  // first key arms the shutdown for exactly the next bus write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     armed_q <= 1'b0;
    else if (wr_en) armed_q <= (addr == A_KILL1) && (wr_data == K_KILL1);
  end
endmodule

// File: rtl/kwdog_count.sv
module kwdog_count
  import kwdog_pkg::*;
#(
  parameter int unsigned CNT_W   = 15,
  parameter int unsigned DEF_TMO = 6000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctl_t             ctl,
  input  logic [CNT_W-1:0] wr_tmo,
  input  logic             tick,
  input  logic             hold,
  output logic [CNT_W-1:0] tmo_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             settle_q,
  output logic             en_q,
  output logic             warn,
  output logic             hit,
  output logic             pulse_q
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO  = CNT_W'(2);
  localparam logic [CNT_W-1:0] INIT = CNT_W'(DEF_TMO);

  logic             run_q, run_n, en_n;
  logic [CNT_W-1:0] cnt_n, tmo_n;

  always_comb begin
    cnt_n = cnt_q;
    tmo_n = tmo_q;
    en_n  = en_q;
    run_n = run_q;
    warn  = 1'b0;
    hit   = 1'b0;
    if (ctl.tmo_we) tmo_n = wr_tmo;
    if (ctl.resume && !en_q) begin
      en_n  = 1'b1;
      run_n = 1'b0;
    end
    if (ctl.kill) begin
      en_n  = 1'b0;
      run_n = 1'b0;
    end
    if (en_q && run_q && tick && !hold) begin
      if (cnt_q <= ONE) begin
        hit   = 1'b1;
        cnt_n = tmo_q;
      end else begin
        warn  = (cnt_q == TWO);
        cnt_n = cnt_q - ONE;
      end
    end
    if (ctl.feed && en_q) begin
      cnt_n = tmo_q;
      run_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q    <= INIT;
      cnt_q    <= INIT;
      en_q     <= 1'b0;
      run_q    <= 1'b0;
      settle_q <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      tmo_q    <= tmo_n;
      cnt_q    <= cnt_n;
      en_q     <= en_n;
      run_q    <= run_n;
      settle_q <= (cnt_n != cnt_q);
      pulse_q  <= hit;
    end
  end
endmodule

// File: rtl/kwdog_top.sv
module kwdog_top
  import kwdog_pkg::*;
#(
  parameter int unsigned CNT_W   = 15,
  parameter int unsigned DEF_TMO = 6000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              dbg_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq,
  output logic              rst_req
);
  ctl_t             ctl;
  logic [CNT_W-1:0] tmo_w, cnt_w;
  logic             settle_w, en_w, warn_w, hit_w;
  logic             evt_q, mask_q, frc_q, jen_q, tout_q;
  logic             frc_n;
  logic [DATA_W-1:0] mux;

  kwdog_keys u_keys (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .ctl(ctl)
  );

  kwdog_count #(.CNT_W(CNT_W), .DEF_TMO(DEF_TMO)) u_count (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .wr_tmo(wr_data[CNT_W-1:0]),
    .tick(tick), .hold(dbg_mode && !jen_q), .tmo_q(tmo_w), .cnt_q(cnt_w),
    .settle_q(settle_w), .en_q(en_w), .warn(warn_w), .hit(hit_w),
    .pulse_q(rst_req)
  );

  assign frc_n = ctl.frc_we ? wr_data[0] : frc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= 1'b0;
      mask_q <= 1'b0;
      frc_q  <= 1'b0;
      jen_q  <= 1'b0;
      tout_q <= 1'b0;
    end else begin
      evt_q <= (evt_q && !ctl.ack) || warn_w || frc_n;
      frc_q <= frc_n;
      if (ctl.mask_we) mask_q <= wr_data[0];
      if (ctl.jtag_we) jen_q  <= wr_data[0];
      if (hit_w)             tout_q <= 1'b1;
      else if (ctl.stat_clr) tout_q <= 1'b0;
    end
  end

  assign irq = evt_q && mask_q;

  always_comb begin
    case (addr)
      A_TMO:   mux = DATA_W'(tmo_w);
      A_KILL2: mux = en_w ? '0 : V_OFF;
      A_STAT:  mux = tout_q ? V_TOUT : '0;
      A_CNT:   mux = DATA_W'(cnt_w) | {settle_w, {(DATA_W-1){1'b0}}};
      A_JTAG:  mux = {{(DATA_W-2){1'b0}}, dbg_mode, jen_q};
      A_EVT:   mux = {{(DATA_W-1){1'b0}}, evt_q};
      A_MASK:  mux = {{(DATA_W-1){1'b0}}, mask_q};
      A_FRC:   mux = {{(DATA_W-1){1'b0}}, frc_q};
      default: mux = '0;
    endcase
  end

  assign rd_data = rd_en ? mux : '0;
endmodule

// File: rtl/kwdog_chk.sv
module kwdog_chk
  import kwdog_pkg::*;
#(
  parameter int unsigned CNT_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              rst_req,
  input logic              en,
  input logic [CNT_W-1:0]  cnt,
  input logic              settle,
  input logic              timed_out,
  input logic              evt
);
  // R5
  reqtick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(tick));
  // R5
  reqstat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> timed_out);
  // R3
  enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !$past(en)) |-> $past(wr_en && addr == A_RESUME && wr_data == K_RESUME));
  // R4
  cnthold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tick) && !$past(wr_en)) |-> $stable(cnt));
  // R11
  settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> settle);
  // R8
  evtrise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt) |-> ($past(tick) || $past(wr_en && addr == A_FRC)));
endmodule

bind kwdog_top kwdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
  .wr_data(wr_data), .rst_req(rst_req), .en(en_w), .cnt(cnt_w),
  .settle(settle_w), .timed_out(tout_q), .evt(evt_q)
);

// File: tb/kwdog_top_test.sv
`timescale 1ns/1ps
module kwdog_top_test;
  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, dbg_mode = 1'b0;
  logic [5:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq, rst_req;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  // model state
  logic [14:0] m_tmo = 15'd6000, m_cnt = 15'd6000;
  bit m_en, m_run, m_arm, m_evt, m_mask, m_frc, m_jen, m_stat;

  kwdog_top uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .dbg_mode(dbg_mode), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .irq(irq), .rst_req(rst_req)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input logic [5:0] a);
    case (a)
      6'h04: return {1'b0, m_tmo};
      6'h0C: return m_en ? 16'h0000 : 16'hDABE;
      6'h10: return m_stat ? 16'hCFE8 : 16'h0000;
      6'h14: return {1'b0, m_cnt};
      6'h18: return {14'd0, dbg_mode, m_jen};
      6'h20: return {15'd0, m_evt};
      6'h24: return {15'd0, m_mask};
      6'h28: return {15'd0, m_frc};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    bit prev;
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    prev = m_arm;
    m_arm = (a == 6'h08 && d == 16'h2BAD);
    case (a)
      6'h00: if (d == 16'hFEED && m_en) begin m_cnt = m_tmo; m_run = 1; end
      6'h04: m_tmo = d[14:0];
      6'h0C: if (prev && d == 16'hCAFE) begin m_en = 0; m_run = 0; end
      6'h10: if (d == 16'hE8B4) m_stat = 0;
      6'h18: m_jen = d[0];
      6'h1C: if (d == 16'hACED && !m_en) begin m_en = 1; m_run = 0; end
      6'h20: if (d[0]) m_evt = 0;
      6'h24: m_mask = d[0];
      6'h28: m_frc = d[0];
      default: ;
    endcase
    if (m_frc) m_evt = 1;
  endtask

  // one tick; checks rst_req in the clock after the edge (R5)
  task automatic tk();
    bit ex = 0;
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    if (m_en && m_run && !(dbg_mode && !m_jen)) begin
      if (m_cnt <= 1) begin ex = 1; m_cnt = m_tmo; m_stat = 1; end
      else begin if (m_cnt == 2) m_evt = 1; m_cnt = m_cnt - 1; end
    end
    chk("R5 rst_req after tick", {15'd0, rst_req}, {15'd0, ex});
  endtask

  task automatic rd(input string req, input logic [5:0] a);
    @(negedge clk);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #2;
    chk(req, rd_data, exp_rd(a));
    rd_en = 1'b0;
  endtask

  task automatic rd_now(input string req, input logic [5:0] a, input logic [15:0] e);
    addr = a; rd_en = 1'b1;
    #2;
    chk(req, rd_data, e);
    rd_en = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned r;
    r = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_now("R1 off code", 6'h0C, 16'hDABE);
    rd_now("R1 timeout", 6'h04, 16'd6000);
    rd_now("R1 count", 6'h14, 16'd6000);
    rd_now("R1 status", 6'h10, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 rst_req", {15'd0, rst_req}, 16'd0);

    // R2 timeout width and unmapped reads
    wr(6'h04, 16'hFFFF);
    rd_now("R2 timeout mask", 6'h04, 16'h7FFF);
    rd_now("R2 write-only feed reads 0", 6'h00, 16'h0000);
    rd_now("R2 unmapped", 6'h3C, 16'h0000);
    wr(6'h04, 16'd5);

    // R3 enable then feed
    wr(6'h00, 16'hFEED);
    rd_now("R3 feed ignored while off", 6'h14, 16'd6000);
    wr(6'h1C, 16'hACED);
    rd_now("R3 enabled", 6'h0C, 16'h0000);
    tk();
    rd("R3 no count before feed", 6'h14);
    wr(6'h00, 16'h1234);
    rd_now("R3 wrong feed key", 6'h14, 16'd6000);
    wr(6'h00, 16'hFEED);
    rd("R3 feed reload", 6'h14);

    // R11 settle flag
    tk();
    rd_now("R11 settling bit set", 6'h14, 16'h8004);
    @(negedge clk);
    rd_now("R11 settling bit clear", 6'h14, 16'h0004);

    // R4 and R8
    tk();
    rd_now("R4 decrement", 6'h14, 16'h8003);
    tk();
    rd("R8 no warning at 3", 6'h20);
    tk();
    rd_now("R8 warning set", 6'h20, 16'h0001);
    chk("R8 irq masked", {15'd0, irq}, 16'd0);
    wr(6'h24, 16'h0001);
    chk("R8 irq unmasked", {15'd0, irq}, 16'd1);
    wr(6'h20, 16'h0001);
    chk("R8 ack clears irq", {15'd0, irq}, 16'd0);

    // R5 expiry
    tk();
    rd_now("R5 reload", 6'h14, 16'h8005);
    chk("R5 one-clock pulse", {15'd0, rst_req}, 16'd1);
    @(negedge clk);
    chk("R5 pulse ended", {15'd0, rst_req}, 16'd0);
    rd_now("R5 status", 6'h10, 16'hCFE8);

    // R6 status key
    wr(6'h10, 16'h1111);
    rd_now("R6 wrong key keeps status", 6'h10, 16'hCFE8);
    wr(6'h10, 16'hE8B4);
    rd_now("R6 cleared", 6'h10, 16'h0000);

    // R9 force
    wr(6'h28, 16'h0001);
    rd_now("R9 force sets event", 6'h20, 16'h0001);
    wr(6'h20, 16'h0001);
    rd_now("R9 ack loses to force", 6'h20, 16'h0001);
    wr(6'h28, 16'h0000);
    wr(6'h20, 16'h0001);
    rd_now("R9 ack after force off", 6'h20, 16'h0000);

    // R10 debug suspend
    dbg_mode = 1'b1;
    rd("R10 debug bit", 6'h18);
    tk();
    rd("R10 suspended", 6'h14);
    wr(6'h18, 16'h0001);
    tk();
    rd("R10 override counts", 6'h14);
    dbg_mode = 1'b0;

    // R7 shutdown sequence
    wr(6'h08, 16'h2BAD);
    wr(6'h04, 16'd7);
    wr(6'h0C, 16'hCAFE);
    rd_now("R7 interrupted sequence", 6'h0C, 16'h0000);
    wr(6'h08, 16'h2BAD);
    wr(6'h0C, 16'hCAFE);
    rd_now("R7 off", 6'h0C, 16'hDABE);
    tk();
    rd("R7 no count when off", 6'h14);

    // random phase
    for (int i = 0; i < 1500; i++) begin
      int unsigned op;
      op = $urandom % 16;
      case (op)
        0, 1, 2, 3, 4, 5: tk();
        6: wr(6'h00, ($urandom % 4 == 0) ? 16'h0BAD : 16'hFEED);
        7: wr(6'h04, ($urandom % 5 == 0) ? 16'($urandom % 2) : 16'(2 + $urandom % 10));
        8: wr(6'h20, 16'($urandom % 2));
        9: wr(6'h24, 16'($urandom % 2));
        10: begin wr(6'h28, 16'h0001); wr(6'h28, 16'h0000); end
        11: wr(6'h10, ($urandom % 2) ? 16'hE8B4 : 16'h0000);
        12: wr(6'h1C, 16'hACED);
        13: begin
          wr(6'h08, 16'h2BAD);
          if ($urandom % 3 == 0) wr(6'h24, {15'd0, m_mask});
          wr(6'h0C, 16'hCAFE);
        end
        14: begin dbg_mode = $urandom % 2; wr(6'h18, 16'($urandom % 2)); end
        default: rd("R7 random off state", 6'h0C);
      endcase
      rd("R4 random count", 6'h14);
      if (i % 4 == 0) rd("R8 random event", 6'h20);
      if (i % 4 == 1) rd("R5 random status", 6'h10);
      chk("R8 random irq", {15'd0, irq}, {15'd0, m_evt && m_mask});
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule